// File: doc/BRIEF.md
# MSI Interrupt Capture Controller

This block collects message-signalled interrupts that arrive as inbound memory writes already reduced to an address and a data word. When a write hits the programmed 64-bit match address, the data word is taken as a vector number. That vector then sets a status bit in one of eight banks of 32 vectors each, but only if the vector is enabled.

Software reads and writes per-bank enable, mask and status words through a simple register port. Status bits are cleared by writing ones. A single registered interrupt line is raised while any status bit is set, enabled and not masked. Software finds the pending vectors of a bank as its status with the masked bits removed.

Top module: `msi_capture`

## Requirements
- R1: After a synchronous reset all enable words read 0, all mask words read 0xFFFFFFFF, all status words read 0, both match-address words read 0, and irq_out is 0.
- R2: Register offsets: match address low word at 0x820 and high word at 0x824. Bank g (0..7) has its enable word at 0x828+12*g, its mask word at +4 and its status word at +8. Enable, mask and match words return the value last written. Read data appears on reg_rdata one cycle after reg_re.
- R3: An inbound write is accepted when msi_valid is high and msi_addr equals {high word, low word}. Its msi_data value n addresses bank n>>5, bit n&31, and at most one status bit is set per accepted write.
- R4: An accepted vector sets its status bit only if that vector's enable bit is 1.
- R5: A write whose msi_data is 256 or more changes no status bit.
- R6: A write whose address differs from the match address changes no status bit.
- R7: Writing a status word clears the bits written as 1 and leaves the others unchanged. Writing it never sets a bit.
- R8: irq_out is the OR over all banks of status AND enable AND NOT mask, registered one cycle after that state. A masked vector still latches status but does not raise irq_out.
- R9: When an accepted vector sets a status bit in the same cycle that a status write clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| msi_valid | input | 1 | Inbound MSI write valid |
| msi_addr | input | 64 | Inbound MSI write address |
| msi_data | input | 32 | Inbound MSI write data (vector number) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
On every cycle the assertions check four things. No status bit appears without an inbound write. A new bit appears only where the enable was set. Out-of-range vectors and address mismatches leave status untouched, and an accepted write sets at most one bit. They also check the reset contents, and that irq_out never rises without a status bit behind it. Several behaviours can only be shown by the bench's scenarios. These are the mapping of a particular vector number onto a particular bank and bit, masking with status still latched, the set-over-clear priority, and the readback through the register map.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int unsigned REG_AW  = 12;
  localparam int unsigned REG_DW  = 32;
  localparam logic [REG_AW-1:0] OFF_MATCH_LO = 12'h820;
  localparam logic [REG_AW-1:0] OFF_MATCH_HI = 12'h824;
  localparam logic [REG_AW-1:0] OFF_BANK0    = 12'h828;
  localparam int unsigned BANK_STRIDE = 12;
  localparam int unsigned OFF_MASK_REL = 4;
  localparam int unsigned OFF_STAT_REL = 8;

  typedef struct packed {
    logic en;
    logic mask;
    logic stat;
  } bank_sel_t;
endpackage

// File: rtl/msi_regdec.sv
module msi_regdec #(
  parameter int unsigned NBANK = 8,
  parameter int unsigned AW    = msi_pkg::REG_AW
) (
  input  logic [AW-1:0]         addr,
  output msi_pkg::bank_sel_t    sel [NBANK],
  output logic                  sel_mlo,
  output logic                  sel_mhi
);
  import msi_pkg::*;

  assign sel_mlo = (addr == AW'(OFF_MATCH_LO));
  assign sel_mhi = (addr == AW'(OFF_MATCH_HI));

  for (genvar g = 0; g < NBANK; g++) begin : g_dec
    localparam int unsigned BASE_G = int'(OFF_BANK0) + BANK_STRIDE * g;
    assign sel[g].en   = (addr == AW'(BASE_G));
    assign sel[g].mask = (addr == AW'(BASE_G + OFF_MASK_REL));
    assign sel[g].stat = (addr == AW'(BASE_G + OFF_STAT_REL));
  end
endmodule

// File: rtl/msi_match.sv
module msi_match #(
  parameter int unsigned NBANK = 8,
  parameter int unsigned BW    = 32,
  parameter int unsigned MAW   = 64,
  parameter int unsigned DW    = 32
) (
  input  logic             valid,
  input  logic [MAW-1:0]   addr,
  input  logic [DW-1:0]    data,
  input  logic [MAW-1:0]   match_addr,
  output logic [NBANK-1:0] bank_hot,
  output logic [BW-1:0]    bit_hot
);
  localparam int unsigned NVEC = NBANK * BW;
  localparam int unsigned BIW  = (BW > 1) ? $clog2(BW) : 1;
  localparam int unsigned GIW  = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic            accept;
  logic [GIW-1:0]  bank_idx;
  logic [BIW-1:0]  bit_idx;

  assign accept   = valid && (addr == match_addr) && (data < DW'(NVEC));
  assign bit_idx  = data[BIW-1:0];
  assign bank_idx = GIW'(data >> BIW);

  always_comb begin
    bank_hot = '0;
    bit_hot  = '0;
    if (accept) begin
      bank_hot[bank_idx] = 1'b1;
      bit_hot[bit_idx]   = 1'b1;
    end
  end
endmodule

// File: rtl/msi_bank.sv
module msi_bank #(
  parameter int unsigned BW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_mask,
  input  logic          wr_stat,
  input  logic [BW-1:0] wdata,
  input  logic [BW-1:0] set_req,
  output logic [BW-1:0] en_q,
  output logic [BW-1:0] mask_q,
  output logic [BW-1:0] stat_q,
  output logic          fire
);
  logic [BW-1:0] clr_vec;
  logic [BW-1:0] set_vec;

  assign clr_vec = wr_stat ? wdata : '0;
  assign set_vec = set_req & en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mask_q <= '1;
      stat_q <= '0;
    end else begin
      if (wr_en)   en_q   <= wdata;
      if (wr_mask) mask_q <= wdata;
      stat_q <= (stat_q & ~clr_vec) | set_vec;
    end
  end

  assign fire = |(stat_q & en_q & ~mask_q);
endmodule

// File: rtl/msi_capture.sv
module msi_capture #(
  parameter int unsigned NBANK = 8,
  parameter int unsigned BW    = 32,
  parameter int unsigned AW    = msi_pkg::REG_AW,
  parameter int unsigned DW    = msi_pkg::REG_DW,
  parameter int unsigned MAW   = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic           reg_re,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic           msi_valid,
  input  logic [MAW-1:0] msi_addr,
  input  logic [DW-1:0]  msi_data,
  output logic           irq_out
);
  import msi_pkg::*;
  localparam int unsigned NVEC = NBANK * BW;

  bank_sel_t         sel [NBANK];
  logic              sel_mlo, sel_mhi;
  logic [MAW-1:0]    match_q;
  logic [NBANK-1:0]  bank_hot;
  logic [BW-1:0]     bit_hot;
  logic [BW-1:0]     en_q   [NBANK];
  logic [BW-1:0]     mask_q [NBANK];
  logic [BW-1:0]     stat_q [NBANK];
  logic [NBANK-1:0]  fire;
  logic [NVEC-1:0]   en_flat, mask_flat, stat_flat;
  logic [DW-1:0]     rd_mux;

  msi_regdec #(.NBANK(NBANK), .AW(AW)) u_dec (
    .addr(reg_addr), .sel(sel), .sel_mlo(sel_mlo), .sel_mhi(sel_mhi)
  );

  msi_match #(.NBANK(NBANK), .BW(BW), .MAW(MAW), .DW(DW)) u_match (
    .valid(msi_valid), .addr(msi_addr), .data(msi_data),
    .match_addr(match_q), .bank_hot(bank_hot), .bit_hot(bit_hot)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    msi_bank #(.BW(BW)) u_bank (
      .clk(clk), .rst(rst),
      .wr_en(reg_we && sel[g].en),
      .wr_mask(reg_we && sel[g].mask),
      .wr_stat(reg_we && sel[g].stat),
      .wdata(reg_wdata[BW-1:0]),
      .set_req(bank_hot[g] ? bit_hot : '0),
      .en_q(en_q[g]), .mask_q(mask_q[g]), .stat_q(stat_q[g]),
      .fire(fire[g])
    );
    assign en_flat[g*BW +: BW]   = en_q[g];
    assign mask_flat[g*BW +: BW] = mask_q[g];
    assign stat_flat[g*BW +: BW] = stat_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
    end else if (reg_we) begin
      if (sel_mlo) match_q[31:0]     <= reg_wdata[31:0];
      if (sel_mhi) match_q[MAW-1:32] <= reg_wdata[MAW-33:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_mlo) rd_mux = match_q[31:0];
    if (sel_mhi) rd_mux = match_q[MAW-1:32];
    for (int g = 0; g < NBANK; g++) begin
      if (sel[g].en)   rd_mux = DW'(en_q[g]);
      if (sel[g].mask) rd_mux = DW'(mask_q[g]);
      if (sel[g].stat) rd_mux = DW'(stat_q[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      if (reg_re) reg_rdata <= rd_mux;
      irq_out <= |fire;
    end
  end
endmodule

// File: rtl/msi_capture_chk.sv
module msi_capture_chk #(
  parameter int unsigned NVEC = 256,
  parameter int unsigned MAW  = 64,
  parameter int unsigned DW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            msi_valid,
  input logic [MAW-1:0]  msi_addr,
  input logic [DW-1:0]   msi_data,
  input logic [MAW-1:0]  match_q,
  input logic [NVEC-1:0] en_flat,
  input logic [NVEC-1:0] mask_flat,
  input logic [NVEC-1:0] stat_flat,
  input logic            irq_out
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_flat == '0 && mask_flat == '1 && stat_flat == '0 && !irq_out));

  assert_one_new_bit_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(stat_flat & ~$past(stat_flat)) <= 1);

  assert_quiet_without_msi_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(msi_valid) |-> ((stat_flat & ~$past(stat_flat)) == '0));

  assert_new_bit_enabled_R4: assert property (@(posedge clk) disable iff (rst)
    ((stat_flat & ~$past(stat_flat) & ~$past(en_flat)) == '0));

  assert_range_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(msi_data) >= DW'(NVEC)) |-> ((stat_flat & ~$past(stat_flat)) == '0));

  assert_mismatch_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(msi_addr) != $past(match_q)) |-> ((stat_flat & ~$past(stat_flat)) == '0));

  assert_irq_has_source_R8: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|stat_flat));
endmodule

bind msi_capture msi_capture_chk #(.NVEC(NBANK*BW), .MAW(MAW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .msi_valid(msi_valid), .msi_addr(msi_addr),
  .msi_data(msi_data), .match_q(match_q), .en_flat(en_flat),
  .mask_flat(mask_flat), .stat_flat(stat_flat), .irq_out(irq_out)
);

// File: tb/tb_msi_capture.sv
module tb_msi_capture;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msi_valid = 1'b0;
  logic [63:0] msi_addr = '0;
  logic [31:0] msi_data = '0;
  logic        irq_out;

  int nchk = 0, nfail = 0;
  localparam logic [63:0] MADDR = 64'h0000_0001_FEE0_0000;

  // {vector[15:0], address matches, expected status bit, expected irq}
  localparam logic [18:0] VEC_TBL [0:6] = '{
    {16'd0,   1'b1, 1'b1, 1'b1},   // R3 R4 bank0 bit0
    {16'd255, 1'b1, 1'b1, 1'b1},   // R3 bank7 bit31
    {16'd101, 1'b1, 1'b1, 1'b0},   // R8 masked vector latches, no irq
    {16'd1,   1'b1, 1'b0, 1'b0},   // R4 not enabled
    {16'd0,   1'b0, 1'b0, 1'b0},   // R6 address mismatch
    {16'd256, 1'b1, 1'b0, 1'b0},   // R5 out of range, aliases bank0 bit0
    {16'd511, 1'b1, 1'b0, 1'b0}    // R5 out of range, aliases bank7 bit31
  };

  msi_capture dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msi_valid(msi_valid), .msi_addr(msi_addr), .msi_data(msi_data),
    .irq_out(irq_out)
  );

  always #5 clk = ~clk;

  function automatic logic [11:0] bank_off(input int g, input int rel);
    return 12'(12'h828 + 12 * g + rel);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    @(negedge clk); reg_re = 1'b0; d = reg_rdata;
  endtask

  task automatic msi(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk); msi_valid = 1'b1; msi_addr = a; msi_data = d;
    @(negedge clk); msi_valid = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset contents
    chk("R1 irq", 32'(irq_out), 32'd0);
    rd(bank_off(0, 0), d); chk("R1 enable0", d, 32'h0);
    rd(bank_off(2, 4), d); chk("R1 mask2", d, 32'hFFFF_FFFF);
    rd(bank_off(7, 8), d); chk("R1 status7", d, 32'h0);
    rd(12'h820, d);        chk("R1 match lo", d, 32'h0);

    // R7 writing ones to status never sets
    wr(bank_off(5, 8), 32'hFFFF_FFFF);
    rd(bank_off(5, 8), d); chk("R7 no set by write", d, 32'h0);

    // setup
    wr(12'h820, MADDR[31:0]);
    wr(12'h824, MADDR[63:32]);
    rd(12'h824, d); chk("R2 match hi", d, 32'h1);
    wr(bank_off(0, 0), 32'h1);
    wr(bank_off(0, 4), 32'h0);
    wr(bank_off(7, 0), 32'h8000_0000);
    wr(bank_off(7, 4), 32'h0);
    wr(bank_off(3, 0), 32'h20);
    rd(bank_off(7, 0), d); chk("R2 enable7", d, 32'h8000_0000);

    for (int i = 0; i < 7; i++) begin
      logic [15:0] v;
      int g, b;
      v = VEC_TBL[i][18:3];
      g = (int'(v) >> 5) & 7;
      b = int'(v) & 31;
      msi(VEC_TBL[i][2] ? MADDR : (MADDR ^ 64'h10), 32'(v));
      @(negedge clk);
      chk($sformatf("R8 irq vec %0d", v), 32'(irq_out), 32'(VEC_TBL[i][0]));
      rd(bank_off(g, 8), d);
      chk($sformatf("R3 R4 R5 R6 status vec %0d", v), 32'(d[b]), 32'(VEC_TBL[i][1]));
      wr(bank_off(g, 8), 32'hFFFF_FFFF);
      @(negedge clk);
    end

    // R9 set wins over same-cycle clear
    @(negedge clk);
    msi_valid = 1'b1; msi_addr = MADDR; msi_data = 32'd0;
    reg_we = 1'b1; reg_addr = bank_off(0, 8); reg_wdata = 32'h1;
    @(negedge clk);
    msi_valid = 1'b0; reg_we = 1'b0;
    rd(bank_off(0, 8), d); chk("R9 set wins", d, 32'h1);
    chk("R8 irq after set", 32'(irq_out), 32'd1);

    // R7 clear with ones
    wr(bank_off(0, 8), 32'h1);
    rd(bank_off(0, 8), d); chk("R7 cleared", d, 32'h0);
    chk("R8 irq dropped", 32'(irq_out), 32'd0);

    // R8 masking after status latched
    msi(MADDR, 32'd255);
    @(negedge clk);
    chk("R8 irq unmasked", 32'(irq_out), 32'd1);
    wr(bank_off(7, 4), 32'h8000_0000);
    @(negedge clk);
    chk("R8 irq masked", 32'(irq_out), 32'd0);
    rd(bank_off(7, 8), d); chk("R8 status kept", d, 32'h8000_0000);
    wr(bank_off(7, 4), 32'h0);
    @(negedge clk);
    chk("R8 irq unmask again", 32'(irq_out), 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule